// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block carries out one processor-side bus transfer at a time over a shared group of pins. In the first clock state of a transfer, sixteen lower lines and four upper lines carry the address. In the later states the lower lines carry data and the upper lines carry a status code. An internal client offers a request that names the direction, the space (memory or I/O), a 20-bit address, 16-bit write data and a high-byte enable. The sequencer latches the request and walks through four clock states. It stretches the transfer with wait states while the external ready input is low.

Around the shared lines the block produces an address strobe, a memory/I/O select, a transmit/receive direction and a data enable. Read data is captured from the lower lines as the final state begins. A single-cycle done pulse follows the final state. When no transfer is in progress, every shared line is released: its output enable is low.

Top module: `mxbus_cycle_engine`

## Requirements
- R1: After reset, and at any time no transfer is in progress, req_ready is 1 and ad_oe, as_oe, ale, den, done, mio, dtr and bhe are all 0.
- R2: In the state after a request is accepted (T1), ale is 1, ad_oe is 1, ad_o equals address bits 15..0, and for a memory transfer as_o equals address bits 19..16 and mio is 1.
- R3: For an I/O transfer, as_o is 0 during T1 whatever address bits 19..16 hold, and mio is 0 for the whole transfer.
- R4: ale is 0 in every state other than T1.
- R5: From T2 through T4, as_o carries the status code {2'b00, io, write}, with as_oe at 1.
- R6: In a write, dtr is 1 from T1 to T4, and from T2 to T4 den is 1, ad_oe is 1 and ad_o equals the write data.
- R7: In a read, dtr is 0, ad_oe is 0 from T2 to T4, and den is 0 in T2 and 1 in T3, in wait states and in T4.
- R8: bus_ready is sampled at the end of T3 and at the end of each wait state. While it is low, wait states follow, and in them every bus output keeps its T3 value.
- R9: For a read, rdata takes the value on ad_i at the clock edge that enters T4. Later changes of ad_i leave rdata unchanged.
- R10: done is 1 for exactly the one cycle after T4, and req_ready is 1 in that same cycle.
- R11: A req_valid raised while a transfer is in progress is ignored. It neither changes the active transfer nor starts another one once that transfer ends.
- R12: bhe equals the request's high-byte enable from T1 to T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client offers a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_hi_en | input | 1 | High-byte enable |
| req_ready | output | 1 | Sequencer idle; request accepted when valid |
| bus_ready | input | 1 | External ready; low inserts wait states |
| ad_i | input | 16 | Lower shared lines, input side |
| ad_o | output | 16 | Lower shared lines, output side |
| ad_oe | output | 1 | Lower lines output enable |
| as_o | output | 4 | Upper shared lines: address, then status |
| as_oe | output | 1 | Upper lines output enable |
| ale | output | 1 | Address latch strobe |
| mio | output | 1 | 1 = memory transfer, 0 = I/O transfer |
| dtr | output | 1 | 1 = transmit, 0 = receive |
| den | output | 1 | Data enable |
| bhe | output | 1 | High-byte enable out |
| rdata | output | 16 | Captured read data |
| done | output | 1 | Transfer-complete pulse |

## Verification
The assertions assume that bus_ready and ad_i hold known, steady values around every rising edge. They also assume that reset is asserted before the first transfer, so that the wait-state hold check and the read-data hold check compare against values sampled after reset. The stimulus changes bus_ready, ad_i and every request field only on falling edges. It sets bus_ready for each sampling edge in the T3 or wait state just before that edge. It drives ad_i with the read value before the edge that enters T4 and with a different value right after it.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int STAT_W = ADDR_W - DATA_W;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic              io;
        logic              hi;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [DATA_W-1:0] ad;
        logic              ad_oe;
        logic [STAT_W-1:0] as;
        logic              as_oe;
        logic              ale;
        logic              mio;
        logic              dtr;
        logic              den;
        logic              bhe;
    } pin_set_t;

    function automatic logic [STAT_W-1:0] status_code(input logic io, input logic wr);
        logic [STAT_W-1:0] s;
        s    = '0;
        s[1] = io;
        s[0] = wr;
        return s;
    endfunction

    function automatic logic [STAT_W-1:0] upper_addr(input bus_req_t r);
        return r.io ? '0 : r.addr[ADDR_W-1:DATA_W];
    endfunction

    function automatic logic is_data_phase(input phase_e p);
        return (p == PH_T2) || (p == PH_T3) || (p == PH_TW) || (p == PH_T4);
    endfunction

endpackage

// File: rtl/mxbus_seq.sv
module mxbus_seq
    import mxbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  bus_req_t req_in,
    input  logic     bus_ready,
    output phase_e   phase,
    output bus_req_t cur,
    output logic     to_t4,
    output logic     finish
);

    phase_e phase_nx;
    logic   accept;

    assign accept = (phase == PH_IDLE) && req_valid;
    assign to_t4  = ((phase == PH_T3) || (phase == PH_TW)) && bus_ready;
    assign finish = (phase == PH_T4);

    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE: if (req_valid) phase_nx = PH_T1;
            PH_T1:   phase_nx = PH_T2;
            PH_T2:   phase_nx = PH_T3;
            PH_T3,
            PH_TW:   phase_nx = bus_ready ? PH_T4 : PH_TW;
            PH_T4:   phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cur   <= '0;
        end else begin
            phase <= phase_nx;
            if (accept) cur <= req_in;
        end
    end

    // R8: a low ready at the end of T3 or of a wait state yields another wait state
    a_r8_wait_on_low_ready: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_T3 || phase == PH_TW) && !bus_ready) |=> (phase == PH_TW));

    // R11: the latched request only changes while idle
    a_r11_req_frozen: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> $stable(cur));

endmodule

// File: rtl/mxbus_drive.sv
module mxbus_drive
    import mxbus_pkg::*;
(
    input  phase_e   phase,
    input  bus_req_t cur,
    output pin_set_t pins
);

    logic active;
    logic data_ph;

    assign active  = (phase != PH_IDLE);
    assign data_ph = is_data_phase(phase);

    always_comb begin
        pins       = '0;
        pins.mio   = active && !cur.io;
        pins.dtr   = active && cur.wr;
        pins.bhe   = active && cur.hi;
        pins.as_oe = active;
        if (phase == PH_T1) begin
            pins.ale   = 1'b1;
            pins.ad    = cur.addr[DATA_W-1:0];
            pins.ad_oe = 1'b1;
            pins.as    = upper_addr(cur);
        end else if (data_ph) begin
            pins.as    = status_code(cur.io, cur.wr);
            pins.ad_oe = cur.wr;
            pins.ad    = cur.wr ? cur.wdata : '0;
            pins.den   = cur.wr || (phase != PH_T2);
        end
    end

endmodule

// File: rtl/mxbus_capture.sv
module mxbus_capture
    import mxbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              to_t4,
    input  logic              is_wr,
    input  logic              finish,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= finish;
            if (to_t4 && !is_wr) rdata <= ad_i;
        end
    end

    // R10: done never lasts two cycles
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/mxbus_cycle_engine.sv
module mxbus_cycle_engine
    import mxbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_hi_en,
    output logic              req_ready,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    output logic [STAT_W-1:0] as_o,
    output logic              as_oe,
    output logic              ale,
    output logic              mio,
    output logic              dtr,
    output logic              den,
    output logic              bhe,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    bus_req_t req_in;
    bus_req_t cur;
    phase_e   phase;
    pin_set_t pins;
    logic     to_t4;
    logic     finish;

    assign req_in = '{wr: req_write, io: req_io, hi: req_hi_en,
                      addr: req_addr, wdata: req_wdata};

    mxbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .bus_ready (bus_ready),
        .phase     (phase),
        .cur       (cur),
        .to_t4     (to_t4),
        .finish    (finish)
    );

    mxbus_drive u_drive (
        .phase (phase),
        .cur   (cur),
        .pins  (pins)
    );

    mxbus_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .to_t4  (to_t4),
        .is_wr  (cur.wr),
        .finish (finish),
        .ad_i   (ad_i),
        .rdata  (rdata),
        .done   (done)
    );

    assign req_ready = (phase == PH_IDLE);
    assign ad_o      = pins.ad;
    assign ad_oe     = pins.ad_oe;
    assign as_o      = pins.as;
    assign as_oe     = pins.as_oe;
    assign ale       = pins.ale;
    assign mio       = pins.mio;
    assign dtr       = pins.dtr;
    assign den       = pins.den;
    assign bhe       = pins.bhe;

    // R1: idle means the shared lines are released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!ad_oe && !as_oe && !den && !ale));

    // R4: the address strobe lasts one cycle
    a_r4_ale_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    // R7: in a receive phase the block never drives the lower lines
    a_r7_read_no_drive: assert property (@(posedge clk) disable iff (rst)
        (den && !dtr) |-> !ad_oe);

    // R8: wait states keep bus outputs as they were
    a_r8_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TW) |-> ($stable(ad_o) && $stable(as_o) && $stable(den) && $stable(ad_oe)));

    // R9: captured read data is not disturbed at completion
    a_r9_rdata_held: assert property (@(posedge clk) disable iff (rst)
        done |-> $stable(rdata));

endmodule

// File: tb/mxbus_cycle_engine_test.sv
`timescale 1ns/1ps
module mxbus_cycle_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_hi_en = 1'b0;
    logic        req_ready;
    logic        bus_ready = 1'b1;
    logic [15:0] ad_i = '0;
    logic [15:0] ad_o;
    logic        ad_oe;
    logic [3:0]  as_o;
    logic        as_oe;
    logic        ale, mio, dtr, den, bhe, done;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mxbus_cycle_engine uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_hi_en(req_hi_en), .req_ready(req_ready), .bus_ready(bus_ready),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .as_o(as_o), .as_oe(as_oe),
        .ale(ale), .mio(mio), .dtr(dtr), .den(den), .bhe(bhe),
        .rdata(rdata), .done(done)
    );

    // {wr, io, hi, waits[2:0], addr[19:0], wdata[15:0], rdval[15:0]}
    localparam bit [57:0] VEC [0:5] = '{
        {1'b1, 1'b0, 1'b1, 3'd0, 20'hA5C3E, 16'h1234, 16'h0000},
        {1'b0, 1'b0, 1'b0, 3'd0, 20'h3F00F, 16'h0000, 16'hBEEF},
        {1'b0, 1'b0, 1'b1, 3'd3, 20'hFFFFF, 16'h0000, 16'h0F0F},
        {1'b1, 1'b1, 1'b0, 3'd2, 20'hF8001, 16'hCAFE, 16'h0000},
        {1'b0, 1'b1, 1'b1, 3'd0, 20'h70042, 16'h0000, 16'h5A5A},
        {1'b1, 1'b0, 1'b1, 3'd1, 20'h00000, 16'hFFFF, 16'h0000}
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string tag);
        check(req_ready == 1'b1, tag, req_ready, 1);
        check({ad_oe, as_oe, ale, den, mio, dtr, bhe} == 7'b0, tag,
              {ad_oe, as_oe, ale, den, mio, dtr, bhe}, 0);
    endtask

    task automatic run_cycle(input bit wr, input bit io, input bit hi, input int waits,
                             input bit [19:0] addr, input bit [15:0] wdata,
                             input bit [15:0] rdval, input bit poke);
        logic [3:0] stat;
        stat = {2'b00, io, wr};
        req_write = wr; req_io = io; req_hi_en = hi; req_addr = addr; req_wdata = wdata;
        req_valid = 1'b1; bus_ready = 1'b1; ad_i = 16'h0000;
        @(negedge clk); // T1
        req_valid = 1'b0;
        check(ale == 1'b1, "R2 ale in T1", ale, 1);
        check(ad_oe && ad_o == addr[15:0], "R2 low address", ad_o, addr[15:0]);
        check(as_oe && as_o == (io ? 4'h0 : addr[19:16]), "R2/R3 upper address", as_o, io ? 4'h0 : addr[19:16]);
        check(mio == !io, "R3 mio", mio, !io);
        check(dtr == wr, "R6/R7 dtr in T1", dtr, wr);
        check(bhe == hi, "R12 bhe in T1", bhe, hi);
        check(req_ready == 1'b0, "R11 busy", req_ready, 0);
        if (poke) begin
            req_valid = 1'b1; req_addr = ~addr; req_wdata = ~wdata; req_write = ~wr;
        end
        @(negedge clk); // T2
        check(ale == 1'b0, "R4 ale in T2", ale, 0);
        check(as_oe && as_o == stat, "R5 status in T2", as_o, stat);
        check(ad_oe == wr && den == wr, "R6/R7 T2 enables", {ad_oe, den}, {wr, wr});
        if (wr) check(ad_o == wdata, "R6 write data T2", ad_o, wdata);
        check(dtr == wr && bhe == hi && mio == !io, "R11 active transfer kept", {dtr, bhe, mio}, {wr, hi, !io});
        @(negedge clk); // T3
        check(den == 1'b1 && ad_oe == wr, "R6/R7 T3 enables", {den, ad_oe}, {1'b1, wr});
        check(as_o == stat && ale == 1'b0, "R5/R4 T3", {ale, as_o}, {1'b0, stat});
        if (wr) check(ad_o == wdata, "R6 write data T3", ad_o, wdata);
        ad_i = rdval;
        bus_ready = (waits == 0);
        for (int w = 0; w < waits; w++) begin
            @(negedge clk); // wait state
            check(den == 1'b1 && ad_oe == wr && ale == 1'b0, "R8 wait enables", {den, ad_oe, ale}, {1'b1, wr, 1'b0});
            check(as_o == stat, "R8 wait status", as_o, stat);
            if (wr) check(ad_o == wdata, "R8 wait data", ad_o, wdata);
            check(req_ready == 1'b0 && done == 1'b0, "R8 still busy", {req_ready, done}, 0);
            bus_ready = (w == waits - 1);
        end
        @(negedge clk); // T4
        check(den == 1'b1 && ad_oe == wr && ale == 1'b0, "R6/R7 T4 enables", {den, ad_oe, ale}, {1'b1, wr, 1'b0});
        check(as_o == stat && bhe == hi, "R5/R12 T4", {bhe, as_o}, {hi, stat});
        check(done == 1'b0, "R10 no done in T4", done, 0);
        if (!wr) check(rdata == rdval, "R9 capture", rdata, rdval);
        ad_i = ~rdval;
        bus_ready = 1'b1;
        if (poke) req_valid = 1'b0;
        @(negedge clk); // idle, done
        check(done == 1'b1, "R10 done pulse", done, 1);
        check_idle("R10/R1 idle with done");
        if (!wr) check(rdata == rdval, "R9 held after ad_i change", rdata, rdval);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", done, 0);
        check_idle(poke ? "R11 no second transfer" : "R1 idle after");
    endtask

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R1 reset state");
        check(done == 1'b0 && rdata == 16'h0, "R1 reset outputs", {done, rdata}, 0);

        foreach (VEC[i]) begin
            run_cycle(VEC[i][57], VEC[i][56], VEC[i][55], int'(VEC[i][54:52]),
                      VEC[i][51:32], VEC[i][31:16], VEC[i][15:0], 1'b0);
        end

        // R11: request raised mid-transfer is ignored
        run_cycle(1'b0, 1'b0, 1'b1, 1, 20'h12345, 16'h0000, 16'h9876, 1'b1);

        // R9: a write leaves earlier read data untouched
        run_cycle(1'b1, 1'b0, 1'b0, 0, 20'h0ABCD, 16'h4444, 16'h0000, 1'b0);
        check(rdata == 16'h9876, "R9 write keeps rdata", rdata, 16'h9876);

        // R1: reset in the middle of a transfer returns to idle
        req_write = 1'b1; req_io = 1'b0; req_addr = 20'h11111; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_idle("R1 reset mid-transfer");
        check(done == 1'b0, "R1 no done after reset", done, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule